// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States and Bus Surrender

This block runs the read and write machine cycles of a simple processor bus. A CPU-side request (address, write data, direction, start) is turned into a fixed sequence of bus phases: an address phase, a data phase, any number of wait phases, and a closing phase in which completion is reported. A slow slave stretches the cycle by holding the ready input low. Each low sample adds one wait phase.

An external master, such as a DMA engine, can ask for the bus by raising a hold request. The sequencer never cuts a cycle short. It gives the bus away only when it is idle or at the close of the current cycle. It then raises an acknowledge and turns off its bus drivers. When the request falls, the acknowledge drops one clock later. The sequencer spends one clock driving the bus again before any stalled CPU request may begin. An optional limit on the number of wait phases ends a cycle that the slave never releases, and flags a timeout.

Top module: `busCycleCtl`

## Requirements
- R1: After reset the block is idle: busDrvEn is 1, busRd, busWr, holdAck and reqDone are 0.
- R2: A request accepted from idle (reqStart high, holdReq low at the clock edge) gives one address cycle with both strobes low. busRd (reqWrite=0) or busWr (reqWrite=1) is then high from the data cycle through the closing cycle. busAddr holds the request address and busWdata holds the write data from the address cycle through the closing cycle.
- R3: If busReady is high at the edge ending the data cycle, reqDone is high in the third cycle after acceptance.
- R4: Each edge, in the data cycle or a wait cycle, at which busReady is low adds one wait cycle. The closing cycle follows the first edge at which busReady is high.
- R5: For a read, the busRdata value present at the edge where busReady is sampled high appears on reqRdata while reqDone is high.
- R6: holdReq is acted on only in idle or at the edge ending the closing cycle. A cycle already begun always runs to its closing cycle with its strobes intact. holdReq wins over reqStart in idle.
- R7: While the bus is surrendered, holdAck is 1, busDrvEn is 0 and both strobes are 0. A reqStart raised meanwhile does not start a cycle.
- R8: After holdReq is sampled low while surrendered, holdAck and busDrvEn both change in the next cycle. That cycle is a reclaim cycle with the bus driven and no strobe, and idle follows it.
- R9: With WAIT_LIMIT > 0, a cycle that has had WAIT_LIMIT wait cycles and samples busReady low again closes next, with reqDone and reqTimeout both high. reqTimeout is 0 in a closing cycle that ended on busReady high.
- R10: reqDone is high for exactly one cycle per bus cycle, and the block returns to idle (or to surrender) after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqStart | input | 1 | CPU request to run a bus cycle |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqAddr | input | AW | Request address |
| reqWdata | input | DW | Request write data |
| reqRdata | output | DW | Read data returned with completion |
| reqDone | output | 1 | Closing cycle, one clock per bus cycle |
| reqTimeout | output | 1 | Cycle closed by the wait limit |
| busAddr | output | AW | Address to the bus |
| busWdata | output | DW | Write data to the bus |
| busRdata | input | DW | Read data from the bus |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busDrvEn | output | 1 | Enable of the bus output drivers |
| busReady | input | 1 | Slave ready, low requests wait cycles |
| holdReq | input | 1 | External master asks for the bus |
| holdAck | output | 1 | Bus has been surrendered |

## Verification
The hardest case to reach is a hold request that arrives in the middle of a stretched cycle. The bus must stay driven until the closing cycle, and the block must then go straight to surrender with a CPU request still pending. The bench gets there with a slave process that holds ready low for a chosen number of strobe cycles. It raises holdReq a few cycles into such a cycle and keeps reqStart raised through the surrender. The bench then drops holdReq and checks the reclaim cycle that comes before the stalled cycle's address phase.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_DATA, PH_WAIT, PH_END, PH_HELD, PH_RECLAIM
  } busPhase_e;

  typedef struct packed {
    logic latchReq;
    logic captureRd;
    logic clrWait;
    logic incWait;
    logic setTimeout;
    logic strobeOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic        busReady,
  input  logic        holdReq,
  input  logic        waitAtLimit,
  output ctrlStrobe_t strb,
  output logic        busDrvEn,
  output logic        holdAck,
  output logic        reqDone
);
  busPhase_e phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      PH_IDLE: begin
        if (holdReq) phaseNext = PH_HELD;
        else if (reqStart) begin
          phaseNext     = PH_ADDR;
          strb.latchReq = 1'b1;
        end
      end
      PH_ADDR: begin
        phaseNext    = PH_DATA;
        strb.clrWait = 1'b1;
      end
      PH_DATA: begin
        strb.strobeOn = 1'b1;
        if (busReady) begin
          phaseNext      = PH_END;
          strb.captureRd = 1'b1;
        end else begin
          phaseNext = PH_WAIT;
        end
      end
      PH_WAIT: begin
        strb.strobeOn = 1'b1;
        if (busReady) begin
          phaseNext      = PH_END;
          strb.captureRd = 1'b1;
        end else if (waitAtLimit) begin
          phaseNext       = PH_END;
          strb.setTimeout = 1'b1;
        end else begin
          strb.incWait = 1'b1;
        end
      end
      PH_END: begin
        strb.strobeOn = 1'b1;
        phaseNext     = holdReq ? PH_HELD : PH_IDLE;
      end
      PH_HELD: begin
        if (!holdReq) phaseNext = PH_RECLAIM;
      end
      PH_RECLAIM: phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  assign busDrvEn = (phase != PH_HELD);
  assign holdAck  = (phase == PH_HELD);
  assign reqDone  = (phase == PH_END);
endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int WAIT_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic          reqWrite,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busRd,
  output logic          busWr,
  output logic [DW-1:0] reqRdata,
  output logic          reqTimeout,
  output logic          waitAtLimit
);
  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ, rdataQ;
  logic          writeQ, timeoutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      writeQ   <= 1'b0;
      rdataQ   <= '0;
      timeoutQ <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        addrQ    <= reqAddr;
        wdataQ   <= reqWdata;
        writeQ   <= reqWrite;
        timeoutQ <= 1'b0;
      end
      if (strb.captureRd && !writeQ) rdataQ <= busRdata;
      if (strb.setTimeout) timeoutQ <= 1'b1;
    end
  end

  generate
    if (WAIT_LIMIT > 0) begin : g_limit
      localparam int CW = $clog2(WAIT_LIMIT + 1);
      localparam logic [CW-1:0] LAST = CW'(WAIT_LIMIT - 1);
      logic [CW-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.clrWait) waitCnt <= '0;
        else if (strb.incWait)     waitCnt <= waitCnt + 1'b1;
      end
      assign waitAtLimit = (waitCnt == LAST);
    end else begin : g_nolimit
      assign waitAtLimit = 1'b0;
    end
  endgenerate

  assign busAddr    = addrQ;
  assign busWdata   = wdataQ;
  assign busRd      = strb.strobeOn && !writeQ;
  assign busWr      = strb.strobeOn && writeQ;
  assign reqRdata   = rdataQ;
  assign reqTimeout = timeoutQ;
endmodule

// File: rtl/busCycleCtl.sv
module busCycleCtl
  import bcc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int WAIT_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqStart,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic [DW-1:0] reqRdata,
  output logic          reqDone,
  output logic          reqTimeout,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  input  logic [DW-1:0] busRdata,
  output logic          busRd,
  output logic          busWr,
  output logic          busDrvEn,
  input  logic          busReady,
  input  logic          holdReq,
  output logic          holdAck
);
  ctrlStrobe_t strb;
  logic        waitAtLimit;

  bcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .busReady(busReady),
    .holdReq(holdReq), .waitAtLimit(waitAtLimit), .strb(strb),
    .busDrvEn(busDrvEn), .holdAck(holdAck), .reqDone(reqDone)
  );

  bcc_datapath #(.AW(AW), .DW(DW), .WAIT_LIMIT(WAIT_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busRd(busRd), .busWr(busWr),
    .reqRdata(reqRdata), .reqTimeout(reqTimeout), .waitAtLimit(waitAtLimit)
  );
endmodule

// File: rtl/busCycleCtl_chk.sv
module busCycleCtl_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqDone,
  input logic          reqTimeout,
  input logic [AW-1:0] busAddr,
  input logic          busRd,
  input logic          busWr,
  input logic          busDrvEn,
  input logic          holdReq,
  input logic          holdAck
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |=> (!(busRd || busWr) || $stable(busAddr))); // R2
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && !reqDone) |=> (busRd || busWr)); // R6
  AST_ACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!holdAck && !holdReq) |=> !holdAck); // R6
  AST_HELD_OFF_BUS: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!busDrvEn && !busRd && !busWr)); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq) |=> (!holdAck && busDrvEn && !busRd && !busWr)); // R8
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    reqTimeout && (busRd || busWr) |-> reqDone); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone); // R10
endmodule

bind busCycleCtl busCycleCtl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .reqDone(reqDone), .reqTimeout(reqTimeout),
  .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busDrvEn(busDrvEn),
  .holdReq(holdReq), .holdAck(holdAck)
);

// File: tb/busCycleCtl_bench.sv
`timescale 1ns/1ps
module busCycleCtl_bench;
  localparam int AW = 16, DW = 8, LIM = 8;

  logic          clk = 1'b0, rstN = 1'b0;
  logic          reqStart = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0, busRdata = '0;
  logic          busReady = 1'b1, holdReq = 1'b0;
  logic [DW-1:0] reqRdata;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          reqDone, reqTimeout, busRd, busWr, busDrvEn, holdAck;

  int nChk = 0, nErr = 0, cyc = 0, waitsLeft = 0;

  always #2 clk = ~clk;

  busCycleCtl #(.AW(AW), .DW(DW), .WAIT_LIMIT(LIM)) u_busCycleCtl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqRdata(reqRdata),
    .reqDone(reqDone), .reqTimeout(reqTimeout), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRd(busRd), .busWr(busWr),
    .busDrvEn(busDrvEn), .busReady(busReady), .holdReq(holdReq),
    .holdAck(holdAck)
  );

  // Behavioural reference: where the cycle is, counted in plain integers.
  // step: 0 none, 1 address, 2 first data, 3 stretched, 4 closing,
  // 5 surrendered, 6 retaking the bus
  int          step = 0, stretched = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mWd = '0, mRd = '0;
  bit          mWr = 0, mTo = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      step = 0; mRd = '0; mTo = 0;
    end else begin
      case (step)
        0: if (holdReq) step = 5;
           else if (reqStart) begin
             step = 1; mAddr = reqAddr; mWd = reqWdata; mWr = reqWrite; mTo = 0;
           end
        1: begin step = 2; stretched = 0; end
        2, 3: begin
          if (busReady) begin
            if (!mWr) mRd = busRdata;
            step = 4;
          end else if (step == 3 && stretched == LIM - 1) begin
            step = 4; mTo = 1;
          end else begin
            if (step == 3) stretched++;
            step = 3;
          end
        end
        4: step = holdReq ? 5 : 0;
        5: if (!holdReq) step = 6;
        default: step = 0;
      endcase
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Compare with the reference on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      bit strobe;
      strobe = (step >= 2 && step <= 4);
      check("R7 R8 busDrvEn", busDrvEn, step != 5);
      check("R6 R7 R8 holdAck", holdAck, step == 5);
      check("R2 R6 busRd", busRd, strobe && !mWr);
      check("R2 R6 busWr", busWr, strobe && mWr);
      check("R3 R4 R10 reqDone", reqDone, step == 4);
      if (step >= 1 && step <= 4) check("R2 busAddr", busAddr, mAddr);
      if (strobe && mWr) check("R2 busWdata", busWdata, mWd);
      if (step == 4) begin
        check("R9 reqTimeout", reqTimeout, mTo);
        if (!mWr && !mTo) check("R5 reqRdata", reqRdata, mRd);
      end
    end
  end

  // Slave: holds ready low for waitsLeft strobe cycles.
  always @(negedge clk) begin
    if ((busRd || busWr) && !reqDone && waitsLeft > 0) begin
      busReady <= 1'b0; waitsLeft <= waitsLeft - 1;
    end else busReady <= 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  task automatic waitDone();
    do @(negedge clk); while (!reqDone);
    reqStart = 1'b0;
  endtask

  task automatic runCycle(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int waits);
    @(negedge clk);
    waitsLeft = waits; busRdata = d ^ 8'h5A;
    reqWrite = wr; reqAddr = a; reqWdata = d; reqStart = 1'b1;
    waitDone();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports while reset is still applied
    check("R1 busDrvEn", busDrvEn, 1);
    check("R1 strobes", busRd | busWr, 0);
    check("R1 holdAck", holdAck, 0);
    check("R1 reqDone", reqDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCycle(0, 16'h1234, 8'hA1, 0);   // R3 zero-wait read
    runCycle(1, 16'hBEEF, 8'h3C, 0);   // R2 write
    runCycle(0, 16'h0F0F, 8'h77, 3);   // R4 R5 stretched read
    runCycle(1, 16'h8001, 8'hC3, 1);   // R4 stretched write
    runCycle(0, 16'h4444, 8'h11, 20);  // R9 wait limit reached
    runCycle(0, 16'h4445, 8'h22, LIM); // R9 ready just in time

    // R6: hold raised in mid-cycle; cycle completes, then surrender
    @(negedge clk);
    waitsLeft = 4; busRdata = 8'h99;
    reqWrite = 0; reqAddr = 16'h2222; reqStart = 1'b1;
    repeat (3) @(negedge clk);
    holdReq = 1'b1;
    waitDone();
    // R7: new request raised while surrendered must stall
    reqWrite = 1; reqAddr = 16'h3333; reqWdata = 8'h5E; reqStart = 1'b1;
    repeat (6) @(negedge clk);
    holdReq = 1'b0;              // R8: reclaim, then the stalled cycle
    waitDone();
    @(negedge clk);

    // R6: hold and start together in idle; hold wins
    waitsLeft = 0;
    holdReq = 1'b1; reqStart = 1'b1; reqWrite = 0; reqAddr = 16'h5555;
    repeat (4) @(negedge clk);
    holdReq = 1'b0;
    waitDone();
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule